// File: doc/BRIEF.md
# Character display command front end

This block sits behind a two-wire serial slave that has already turned the bus into bytes, start strobes and stop strobes. It reads the stream that follows the slave address. Control bytes in that stream say where each following byte goes: to an 8-bit instruction holding register or to an 8-bit data holding register. An instruction byte is passed on to the display core as a one-cycle strobe. A data byte becomes a display RAM write at the current address, and the address counter then steps by one in the configured direction.

While an accepted instruction is executing, a busy flag is held for a programmable number of cycles. Instruction bytes that arrive in that window are discarded. The status read is exempt: a read transfer always returns the busy flag together with the address counter. Whether a transfer reads or writes is decided by the slave address, so reads reach this block as a separate request strobe.

The block decodes only the instructions it needs itself. A set-address instruction loads the address counter, and an entry-mode instruction picks the step direction. Every accepted instruction, whatever its code, is also forwarded to the display core.

Top module: `lcdfe_top`

## Requirements
- R1: After reset the block shows no RAM write and no instruction strobe, the busy flag is 0, the address counter is 0 and the step direction is upward.
- R2: In a control byte, bit 6 selects the target of the bytes that follow it: 0 selects the instruction register and 1 selects the data register. Bits 5 to 0 have no effect on routing.
- R3: A control byte with bit 7 = 1 routes exactly one following byte. The byte after that one is parsed as a new control byte.
- R4: A control byte with bit 7 = 0 routes every later byte to the selected register until the next start or stop strobe, and none of those bytes is parsed as a control byte, whatever its value.
- R5: A start strobe or a stop strobe makes the next received byte a control byte. This includes a repeated start in the middle of a transfer.
- R6: An accepted instruction loads the busy counter from `exec_cycles_i`. The busy flag then reads 1 for exactly that many clock edges. A value of 0 never raises the flag.
- R7: An instruction byte that arrives while the flag is 1 is dropped. It gives no strobe and leaves the address counter and the step direction unchanged.
- R8: A read request returns `{busy, address counter}` on `rd_data_o` one cycle later with `rd_valid_o` high. This happens whether or not the block is busy.
- R9: A routed data byte gives `ram_we_o` for one cycle, one cycle after the byte. The write uses the address held before the byte arrived. The counter then moves by +1 or -1, modulo 2^AW.
- R10: An accepted instruction with bit 7 = 1 loads its bits 6 to 0 into the address counter. An accepted instruction matching 0000_01Dx sets the direction: D = 1 steps upward and D = 0 steps downward.
- R11: Each accepted instruction byte appears on `instr_byte_o` with `instr_valid_o` high for one cycle, one cycle after it was received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start_i | input | 1 | Start or repeated-start strobe |
| bus_stop_i | input | 1 | Stop strobe |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| exec_cycles_i | input | CW | Busy duration loaded on each accepted instruction |
| rd_req_i | input | 1 | Status read request |
| rd_valid_o | output | 1 | Status byte valid |
| rd_data_o | output | AW+1 | Busy flag (MSB) and address counter |
| instr_valid_o | output | 1 | Accepted-instruction strobe |
| instr_byte_o | output | 8 | Accepted instruction |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | AW | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |

## Verification
The bench builds the block with AW = 7 and CW = 4. With a 7-bit counter, one set-address instruction reaches both ends of the address space, so wrap-around in each direction takes only a few bytes. The 4-bit busy counter lets the bench walk the whole busy window cycle by cycle. It programs a duration of 0 for the vector walk, so instructions are never blocked there, and a duration of 3 for the directed busy tests. Those tests read the flag at its last set cycle and at its first clear cycle, and they send an instruction into the window that must be dropped.

// File: rtl/lcdfe_pkg.sv
// Package: lcdfe_pkg
// Shared constants and types for the display command front end.
// Assumes bytes on the serial link are always 8 bits wide.
package lcdfe_pkg;
    localparam int BYTE_W = 8;

    // Control-byte field positions that the parser decodes
    localparam int CTRL_MORE_BIT = 7;
    localparam int CTRL_SEL_BIT  = 6;

    // Parser states: expecting control, routing one byte, routing the rest
    typedef enum logic [1:0] {
        PS_CTRL   = 2'd0,
        PS_ONE    = 2'd1,
        PS_STREAM = 2'd2
    } parse_state_e;
endpackage

// File: rtl/lcdfe_parser.sv
// Module: lcdfe_parser
// Splits the received byte stream into control bytes and routed bytes.
// A control byte with the continuation bit set routes one byte and then
// expects another control byte. With the bit clear it routes every later
// byte until a start or stop strobe.
// Assumes start/stop never coincide with a byte strobe; if they do, the
// strobe wins and the byte is dropped.
module lcdfe_parser
    import lcdfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              route_valid_o,
    output logic              route_sel_o,
    output logic [BYTE_W-1:0] route_byte_o
);
    parse_state_e state_q;
    logic         sel_q;
    logic         frame_evt;
    logic         take_byte;

    // Frame boundary and accepted-byte qualifiers
    always_comb begin
        frame_evt = start_i | stop_i;
        take_byte = byte_valid_i & ~frame_evt;
    end

    // Parser state and latched register select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_CTRL;
            sel_q   <= 1'b0;
        end else if (frame_evt) begin
            state_q <= PS_CTRL;
        end else if (take_byte) begin
            unique case (state_q)
                PS_CTRL: begin
                    sel_q   <= byte_i[CTRL_SEL_BIT];
                    state_q <= byte_i[CTRL_MORE_BIT] ? PS_ONE : PS_STREAM;
                end
                PS_ONE:    state_q <= PS_CTRL;
                PS_STREAM: state_q <= PS_STREAM;
                default:   state_q <= PS_CTRL;
            endcase
        end
    end

    // Route any non-control byte to the latched target
    always_comb begin
        route_valid_o = take_byte & (state_q != PS_CTRL);
        route_sel_o   = sel_q;
        route_byte_o  = byte_i;
    end

    // A frame strobe always returns the parser to control parsing
    p_frame_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> (state_q == PS_CTRL));

    // A single-byte route is followed by control parsing again
    p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ONE && take_byte) |=> (state_q == PS_CTRL));

    // Streaming mode persists until a frame strobe
    p_stream_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STREAM && !frame_evt) |=> (state_q == PS_STREAM));
endmodule

// File: rtl/lcdfe_busy.sv
// Module: lcdfe_busy
// Down-counter that holds the busy flag for a programmed number of edges
// after each load. Assumes the caller never loads while busy.
module lcdfe_busy #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          busy_o
);
    logic [CW-1:0] cnt_q;

    // Load on accept, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy whenever the counter has not run out
    always_comb busy_o = (cnt_q != '0);

    // A nonzero load raises the flag on the next cycle
    p_busy_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> busy_o);

    // The counter drops by exactly one per idle edge
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // The caller must gate loads on the flag
    p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
endmodule

// File: rtl/lcdfe_addr.sv
// Module: lcdfe_addr
// Display RAM address counter and write port. Set-address and entry-mode
// instructions update it. Each data byte issues a write and then steps the
// counter. Assumes instruction and data strobes are never both high.
module lcdfe_addr
    import lcdfe_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_acc_i,
    input  logic [BYTE_W-1:0] instr_i,
    input  logic              data_wr_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [AW-1:0]     ac_o,
    output logic              ram_we_o,
    output logic [AW-1:0]     ram_addr_o,
    output logic [BYTE_W-1:0] ram_wdata_o
);
    logic [AW-1:0] ac_q;
    logic          up_q;
    logic          is_set_addr;
    logic          is_entry;

    // Instruction classes this unit reacts to
    always_comb begin
        is_set_addr = instr_i[7];
        is_entry    = (instr_i[7:2] == 6'b000001);
    end

    // Address counter and step direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            up_q <= 1'b1;
        end else if (instr_acc_i) begin
            if (is_set_addr) ac_q <= AW'(instr_i[6:0]);
            if (is_entry)    up_q <= instr_i[1];
        end else if (data_wr_i) begin
            ac_q <= up_q ? ac_q + 1'b1 : ac_q - 1'b1;
        end
    end

    // Registered RAM write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
        end else begin
            ram_we_o <= data_wr_i;
            if (data_wr_i) begin
                ram_addr_o  <= ac_q;
                ram_wdata_o <= data_i;
            end
        end
    end

    // Expose the counter for status reads
    always_comb ac_o = ac_q;

    // Each data write moves the counter one step in the set direction
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && !instr_acc_i) |=>
        (ac_q == ($past(up_q) ? $past(ac_q) + 1'b1 : $past(ac_q) - 1'b1)));

    // A write strobe only follows a data byte
    p_we_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> $past(data_wr_i));

    // Without any strobe the counter holds still
    p_ac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_acc_i && !data_wr_i) |=> $stable(ac_q));
endmodule

// File: rtl/lcdfe_top.sv
// Module: lcdfe_top
// Command front end for a character display behind a two-wire serial
// slave. It routes instruction and data bytes, gates instructions on the
// busy flag, drives the RAM write port and answers status reads.
// Assumes the serial slave decodes the slave address and the read/write
// bit, so reads reach this block as rd_req_i strobes.
module lcdfe_top
    import lcdfe_pkg::*;
#(
    parameter int AW = 7,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start_i,
    input  logic              bus_stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CW-1:0]     exec_cycles_i,
    input  logic              rd_req_i,
    output logic              rd_valid_o,
    output logic [AW:0]       rd_data_o,
    output logic              instr_valid_o,
    output logic [BYTE_W-1:0] instr_byte_o,
    output logic              ram_we_o,
    output logic [AW-1:0]     ram_addr_o,
    output logic [BYTE_W-1:0] ram_wdata_o
);
    logic              route_valid;
    logic              route_sel;
    logic [BYTE_W-1:0] route_byte;
    logic              busy;
    logic              instr_acc;
    logic              data_wr;
    logic [AW-1:0]     ac;

    lcdfe_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (bus_start_i),
        .stop_i       (bus_stop_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .route_valid_o(route_valid),
        .route_sel_o  (route_sel),
        .route_byte_o (route_byte)
    );

    // Instructions pass only when idle; data is never gated
    always_comb begin
        instr_acc = route_valid & ~route_sel & ~busy;
        data_wr   = route_valid &  route_sel;
    end

    lcdfe_busy #(.CW(CW)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (instr_acc),
        .load_val_i (exec_cycles_i),
        .busy_o     (busy)
    );

    lcdfe_addr #(.AW(AW)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_acc_i (instr_acc),
        .instr_i     (route_byte),
        .data_wr_i   (data_wr),
        .data_i      (route_byte),
        .ac_o        (ac),
        .ram_we_o    (ram_we_o),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o)
    );

    // Instruction register and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_valid_o <= 1'b0;
            instr_byte_o  <= '0;
        end else begin
            instr_valid_o <= instr_acc;
            if (instr_acc) instr_byte_o <= route_byte;
        end
    end

    // Status read: busy flag above the address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_req_i;
            if (rd_req_i) rd_data_o <= {busy, ac};
        end
    end

    // A byte reaches at most one of the two registers
    p_single_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we_o && instr_valid_o));

    // A forwarded instruction was never taken while busy
    p_iv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |-> !$past(busy));

    // Every status request is answered on the next cycle
    p_read_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o);
endmodule

// File: tb/lcdfe_top_test.sv
module lcdfe_top_test;
    localparam int AW = 7;
    localparam int CW = 4;
    localparam int NV = 23;

    // Vector: op(2) byte(8) exp_we(1) exp_addr(7) exp_wd(8) exp_iv(1) exp_ib(8)
    // op: 0 idle, 1 byte, 2 start, 3 stop
    localparam logic [34:0] VEC [NV] = '{
        {2'd2, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // start
        {2'd1, 8'hC0, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl more, data
        {2'd1, 8'h41, 1'b1, 7'h00, 8'h41, 1'b0, 8'h00}, // data @0 (R2 R9)
        {2'd1, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl last, instr (R3)
        {2'd1, 8'h85, 1'b0, 7'h00, 8'h00, 1'b1, 8'h85}, // set addr 5 (R10 R11)
        {2'd1, 8'h04, 1'b0, 7'h00, 8'h00, 1'b1, 8'h04}, // entry down (R4)
        {2'd3, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // stop
        {2'd2, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // start
        {2'd1, 8'h5F, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl last data, junk low bits
        {2'd1, 8'h33, 1'b1, 7'h05, 8'h33, 1'b0, 8'h00}, // data @5, dec
        {2'd1, 8'h34, 1'b1, 7'h04, 8'h34, 1'b0, 8'h00}, // data @4
        {2'd3, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // stop
        {2'd2, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // start
        {2'd1, 8'h80, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl more instr
        {2'd1, 8'h06, 1'b0, 7'h00, 8'h00, 1'b1, 8'h06}, // entry up
        {2'd1, 8'hC0, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // parsed as ctrl (R3)
        {2'd1, 8'h77, 1'b1, 7'h03, 8'h77, 1'b0, 8'h00}, // data @3
        {2'd1, 8'h40, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl last data
        {2'd1, 8'hC0, 1'b1, 7'h04, 8'hC0, 1'b0, 8'h00}, // not ctrl (R4)
        {2'd2, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // repeated start (R5)
        {2'd1, 8'h40, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}, // ctrl again
        {2'd1, 8'h11, 1'b1, 7'h05, 8'h11, 1'b0, 8'h00}, // data @5
        {2'd3, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 8'h00}  // stop
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_start_i = 1'b0;
    logic          bus_stop_i = 1'b0;
    logic          byte_valid_i = 1'b0;
    logic [7:0]    byte_i = '0;
    logic [CW-1:0] exec_cycles_i = '0;
    logic          rd_req_i = 1'b0;
    logic          rd_valid_o;
    logic [AW:0]   rd_data_o;
    logic          instr_valid_o;
    logic [7:0]    instr_byte_o;
    logic          ram_we_o;
    logic [AW-1:0] ram_addr_o;
    logic [7:0]    ram_wdata_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lcdfe_top #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_start_i(bus_start_i), .bus_stop_i(bus_stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .exec_cycles_i(exec_cycles_i), .rd_req_i(rd_req_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .instr_valid_o(instr_valid_o), .instr_byte_o(instr_byte_o),
        .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic drive(input logic [1:0] op, input logic [7:0] b);
        bus_start_i  = (op == 2'd2);
        bus_stop_i   = (op == 2'd3);
        byte_valid_i = (op == 2'd1);
        byte_i       = b;
        @(negedge clk);
        bus_start_i  = 1'b0;
        bus_stop_i   = 1'b0;
        byte_valid_i = 1'b0;
    endtask

    task automatic status(input string req, input int exp);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid_o), 1);
        check({req, " status"}, int'(rd_data_o), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ram_we", int'(ram_we_o), 0);
        check("R1 instr_valid", int'(instr_valid_o), 0);
        status("R1", 8'h00);

        // Vector walk, no busy blocking
        exec_cycles_i = 4'd0;
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VEC[i];
            drive(v[34:33], v[32:25]);
            check($sformatf("R9 v%0d we", i), int'(ram_we_o), int'(v[24]));
            if (v[24]) begin
                check($sformatf("R9 v%0d addr", i), int'(ram_addr_o), int'(v[23:17]));
                check($sformatf("R2 v%0d wdata", i), int'(ram_wdata_o), int'(v[16:9]));
            end
            check($sformatf("R11 v%0d iv", i), int'(instr_valid_o), int'(v[8]));
            if (v[8]) check($sformatf("R11 v%0d ib", i), int'(instr_byte_o), int'(v[7:0]));
        end
        status("R9 ac after walk", 8'h06);

        // R9 upward wrap at the top address
        drive(2'd2, 8'h00); drive(2'd1, 8'h80); drive(2'd1, 8'hFF);
        check("R10 set 7F", int'(instr_valid_o), 1);
        drive(2'd1, 8'h40); drive(2'd1, 8'hAA);
        check("R9 write at 7F", int'(ram_addr_o), 8'h7F);
        status("R9 wrap up", 8'h00);
        drive(2'd3, 8'h00);

        // R9 downward wrap from zero
        drive(2'd2, 8'h00); drive(2'd1, 8'h00); drive(2'd1, 8'h04);
        drive(2'd2, 8'h00); drive(2'd1, 8'h40); drive(2'd1, 8'h55);
        check("R9 write at 0", int'(ram_addr_o), 0);
        status("R9 wrap down", 8'h7F);
        drive(2'd3, 8'h00);

        // R6 R7 R8 busy window of 3 edges
        exec_cycles_i = 4'd3;
        drive(2'd2, 8'h00); drive(2'd1, 8'h00); drive(2'd1, 8'h90);
        check("R6 accepted", int'(instr_valid_o), 1);
        status("R8 busy read", 8'h90);
        drive(2'd1, 8'hA0);
        check("R7 dropped", int'(instr_valid_o), 0);
        status("R6 last busy", 8'h90);
        status("R6 cleared", 8'h10);
        drive(2'd1, 8'h06);
        check("R7 retry accepted", int'(instr_valid_o), 1);
        drive(2'd3, 8'h00);
        repeat (4) @(negedge clk);

        // R7 dropped entry-mode leaves direction upward
        drive(2'd2, 8'h00); drive(2'd1, 8'h00); drive(2'd1, 8'h90);
        drive(2'd1, 8'h04);
        check("R7 entry dropped", int'(instr_valid_o), 0);
        drive(2'd3, 8'h00);
        repeat (4) @(negedge clk);
        drive(2'd2, 8'h00); drive(2'd1, 8'h40); drive(2'd1, 8'h01);
        drive(2'd3, 8'h00);
        status("R7 dir kept", 8'h11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule